// File: doc/BRIEF.md
# PWM / Interval Timer Channel with Gated Prescaler

This block is a single 8-bit timer channel with its own clock prescaler. A free-running prescaler counts the system clock and produces three count enables, one every 4, 16 and 64 system-clock cycles. A select input picks one of them as the count rate of an 8-bit up-counter. The channel runs in one of two modes. In PWM mode the counter wraps at the top of a selectable 6-, 7- or 8-bit period and drives a pulse-width output whose high time follows the compare value. In interval-timer mode the counter runs from zero up to the compare value, pulses a match strobe when it gets there, and restarts.

The compare value is held in a buffered pair. In PWM mode a write goes into the buffer and reaches the active compare register only when the period wraps, so every period is generated whole with a single duty value. In timer mode a write goes straight to the active register. Separate run inputs gate the prescaler and the counter. Dropping either one clears the stage it gates.

Top module: `pwm_interval_timer`

## Requirements
- R1: After reset, count_o is 0 and pwm_o, match_o and ovf_o are low. The prescaler, the compare buffer and the active compare register are all 0.
- R2: While presc_run_i is low the prescaler is held at zero and no count enable is produced, so count_o does not change. Once presc_run_i is raised, the first count with clk_sel_i = 0 comes exactly 4 clock cycles later, no matter how far the prescaler had got before it was stopped.
- R3: clk_sel_i selects the count rate: 0 gives one count per 4 clock cycles, 1 gives one per 16, and 2 or 3 gives one per 64.
- R4: In PWM mode (timer_mode_i = 0), per_sel_i sets the period width n: 0 or 3 gives 8 bits, 1 gives 7 bits and 2 gives 6 bits. The counter counts 0 up to 2^n−1 and then wraps to 0, giving a period of 2^n counts. At each wrap ovf_o pulses while count_o reads 0.
- R5: In PWM mode pwm_o goes high at the wrap and goes low when the counter reaches the compare value C, so it stays high for C counts of every 2^n-count period. It stays low throughout when C = 0 and high throughout when C ≥ 2^n.
- R6: In PWM mode a compare write is stored in the buffer and takes effect only from the next wrap. The period in progress keeps its old compare value.
- R7: In timer mode (timer_mode_i = 1) a compare write goes directly to the active register. The counter counts 0 up to C, pulses match_o when it reaches C, and returns to 0 on the next count, giving C+1 counts between matches. ovf_o never pulses in this mode.
- R8: While cnt_run_i is low the counter is cleared to 0 and held there, and neither strobe pulses.
- R9: match_o and ovf_o are each one clock cycle wide per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (fundamental) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_run_i | input | 1 | Prescaler run; low clears and stops the prescaler |
| cnt_run_i | input | 1 | Counter run; low clears and holds the counter |
| timer_mode_i | input | 1 | 0 = PWM mode, 1 = interval-timer mode |
| clk_sel_i | input | 2 | Count rate: 0 = /4, 1 = /16, 2 or 3 = /64 |
| per_sel_i | input | 2 | PWM period width: 0 or 3 = 8 bits, 1 = 7 bits, 2 = 6 bits |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 8 | Compare write data |
| count_o | output | 8 | Current up-counter value |
| match_o | output | 1 | One-cycle compare-match strobe |
| ovf_o | output | 1 | One-cycle PWM period-wrap strobe |
| pwm_o | output | 1 | PWM output flip-flop |

## Verification
The bench stops the prescaler partway through its cycle and restarts it. A prescaler that kept its phase would produce the next count too early, and the bench would see it. It measures the period and high time under several rate, width and compare settings, including compare values of 0, of 2^n−1 and above 2^n. A duty off by one count, a wrong wrap point for 6 or 7 bits, or a missing saturation would each change those counts. It writes a new compare value in the middle of a PWM period and samples pwm_o past the old compare point. A design that loaded the value at once would still be high there. In timer mode it measures the spacing between matches after a write. A design that buffered writes in this mode would keep the old spacing.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Count-rate selection codes
    typedef enum logic [1:0] {
        RATE_DIV4     = 2'd0,
        RATE_DIV16    = 2'd1,
        RATE_DIV64    = 2'd2,
        RATE_DIV64_B  = 2'd3
    } rate_sel_e;

    // PWM period width codes
    typedef enum logic [1:0] {
        PER_FULL   = 2'd0,
        PER_LESS1  = 2'd1,
        PER_LESS2  = 2'd2,
        PER_FULL_B = 2'd3
    } per_sel_e;

    // Number of bits removed from the full counter width for a period code
    function automatic int unsigned period_shift(per_sel_e sel);
        case (sel)
            PER_LESS1: return 1;
            PER_LESS2: return 2;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
    parameter int NUM_TAPS = 3,
    parameter int TAP_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    output logic [NUM_TAPS-1:0] tick_o
);
    localparam int PW = NUM_TAPS * TAP_BITS;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Tap i fires once every 2^((i+1)*TAP_BITS) cycles while running
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tick_o[i] = run_i && (&st_q.cnt[(i+1)*TAP_BITS-1:0]);
    end

endmodule

// File: rtl/pwmt_cmp_buf.sv
module pwmt_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         direct_i,
    input  logic         load_i,
    output logic [W-1:0] buf_o,
    output logic [W-1:0] act_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.hold = wdata_i;
        end
        if (wr_i && direct_i) begin
            st_d.act = wdata_i;
        end else if (load_i) begin
            st_d.act = st_q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_o = st_q.hold;
    assign act_o = st_q.act;

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         timer_mode_i,
    input  logic [1:0]   per_sel_i,
    input  logic [W-1:0] cmp_act_i,
    input  logic [W-1:0] cmp_buf_i,
    output logic         load_o,
    output logic [W-1:0] count_o,
    output logic         match_o,
    output logic         ovf_o,
    output logic         pwm_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         match;
        logic         ovf;
        logic         pwm;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic         adv;
    logic         wrap;
    logic         ovf_ev;
    logic         match_ev;
    logic [W-1:0] top;
    logic [W-1:0] cmp_next;

    always_comb begin
        top      = ALL_ONES >> period_shift(per_sel_e'(per_sel_i));
        adv      = tick_i && run_i;
        wrap     = (st_q.cnt >= top);
        ovf_ev   = adv && !timer_mode_i && wrap;
        // At a wrap the buffered value becomes the one in force
        cmp_next = ovf_ev ? cmp_buf_i : cmp_act_i;

        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (adv) begin
            if (timer_mode_i) begin
                st_d.cnt = (st_q.cnt == cmp_act_i) ? '0 : st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            end
        end

        match_ev  = adv && (st_d.cnt == cmp_next);
        st_d.match = match_ev;
        st_d.ovf   = ovf_ev;

        if (!timer_mode_i) begin
            if (ovf_ev) begin
                st_d.pwm = (cmp_next != '0);
            end else if (match_ev) begin
                st_d.pwm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o  = ovf_ev;
    assign count_o = st_q.cnt;
    assign match_o = st_q.match;
    assign ovf_o   = st_q.ovf;
    assign pwm_o   = st_q.pwm;

endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer #(
    parameter int CNT_W    = 8,
    parameter int NUM_TAPS = 3,
    parameter int TAP_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_run_i,
    input  logic             cnt_run_i,
    input  logic             timer_mode_i,
    input  logic [1:0]       clk_sel_i,
    input  logic [1:0]       per_sel_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o,
    output logic             ovf_o,
    output logic             pwm_o
);
    localparam int LAST_TAP = NUM_TAPS - 1;

    logic [NUM_TAPS-1:0] taps;
    logic                sel_tick;
    int                  sel_idx;
    logic                load;
    logic [CNT_W-1:0]    cmp_buf;
    logic [CNT_W-1:0]    cmp_act;

    pwmt_prescaler #(
        .NUM_TAPS (NUM_TAPS),
        .TAP_BITS (TAP_BITS)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (presc_run_i),
        .tick_o (taps)
    );

    // Codes past the last tap fall back to the slowest rate
    always_comb begin
        sel_idx  = (int'(clk_sel_i) > LAST_TAP) ? LAST_TAP : int'(clk_sel_i);
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (i == sel_idx) begin
                sel_tick = taps[i];
            end
        end
    end

    pwmt_cmp_buf #(
        .W (CNT_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cmp_wr_i),
        .wdata_i  (cmp_wdata_i),
        .direct_i (timer_mode_i),
        .load_i   (load),
        .buf_o    (cmp_buf),
        .act_o    (cmp_act)
    );

    pwmt_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (sel_tick),
        .run_i        (cnt_run_i),
        .timer_mode_i (timer_mode_i),
        .per_sel_i    (per_sel_i),
        .cmp_act_i    (cmp_act),
        .cmp_buf_i    (cmp_buf),
        .load_o       (load),
        .count_o      (count_o),
        .match_o      (match_o),
        .ovf_o        (ovf_o),
        .pwm_o        (pwm_o)
    );

endmodule

// File: rtl/pwm_interval_timer_chk.sv
module pwm_interval_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             presc_run_i,
    input logic             cnt_run_i,
    input logic             timer_mode_i,
    input logic [CNT_W-1:0] count_o,
    input logic             match_o,
    input logic             ovf_o,
    input logic             pwm_o
);

    assert_presc_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!presc_run_i && cnt_run_i) |=> $stable(count_o));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0));

    assert_rise_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> ovf_o);

    assert_no_ovf_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !$past(timer_mode_i));

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_run_i |=> (count_o == '0) && !match_o && !ovf_o);

    assert_match_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    assert_ovf_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

endmodule

bind pwm_interval_timer pwm_interval_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .presc_run_i  (presc_run_i),
    .cnt_run_i    (cnt_run_i),
    .timer_mode_i (timer_mode_i),
    .count_o      (count_o),
    .match_o      (match_o),
    .ovf_o        (ovf_o),
    .pwm_o        (pwm_o)
);

// File: tb/pwm_interval_timer_tb_top.sv
module pwm_interval_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       presc_run_i;
    logic       cnt_run_i;
    logic       timer_mode_i;
    logic [1:0] clk_sel_i;
    logic [1:0] per_sel_i;
    logic       cmp_wr_i;
    logic [7:0] cmp_wdata_i;
    logic [7:0] count_o;
    logic       match_o;
    logic       ovf_o;
    logic       pwm_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pwm_interval_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .presc_run_i  (presc_run_i),
        .cnt_run_i    (cnt_run_i),
        .timer_mode_i (timer_mode_i),
        .clk_sel_i    (clk_sel_i),
        .per_sel_i    (per_sel_i),
        .cmp_wr_i     (cmp_wr_i),
        .cmp_wdata_i  (cmp_wdata_i),
        .count_o      (count_o),
        .match_o      (match_o),
        .ovf_o        (ovf_o),
        .pwm_o        (pwm_o)
    );

    typedef struct packed {
        logic [1:0] rate;
        logic [1:0] per;
        logic [7:0] cmp;
        int         exp_period;
        int         exp_high;
    } vec_t;

    // rate, period code, compare, expected period and high time in clock cycles
    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd0, 8'd64,  1024, 256},
        '{2'd0, 2'd2, 8'd16,  256,  64},
        '{2'd1, 2'd1, 8'd100, 2048, 1600},
        '{2'd0, 2'd2, 8'd0,   256,  0},
        '{2'd0, 2'd2, 8'd200, 256,  256},
        '{2'd2, 2'd2, 8'd63,  4096, 4032},
        '{2'd0, 2'd0, 8'd255, 1024, 1020},
        '{2'd3, 2'd2, 8'd1,   4096, 64}
    };

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cmp(input logic [7:0] val);
        cmp_wdata_i = val;
        cmp_wr_i    = 1'b1;
        @(negedge clk);
        cmp_wr_i    = 1'b0;
    endtask

    // Wait for the next wrap strobe, then count cycles and high samples to the following one
    task automatic measure(output int per, output int hi, output int ovf_len);
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!ovf_o && guard < 20000);
        per = 0;
        hi = 0;
        ovf_len = 0;
        do begin
            if (ovf_o) ovf_len++;
            per++;
            if (pwm_o) hi++;
            @(negedge clk);
        end while (!ovf_o && per < 20000);
    endtask

    task automatic wait_match(output int guard);
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!match_o && guard < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        int per, hi, olen, g, n, maxc;
        bit ovf_seen, bad_strobe;

        rst_n        = 1'b0;
        presc_run_i  = 1'b0;
        cnt_run_i    = 1'b0;
        timer_mode_i = 1'b0;
        clk_sel_i    = 2'd0;
        per_sel_i    = 2'd0;
        cmp_wr_i     = 1'b0;
        cmp_wdata_i  = 8'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(count_o == 8'd0, "R1 count after reset", count_o, 0);
        check({pwm_o, match_o, ovf_o} == 3'b000, "R1 outputs after reset",
              {pwm_o, match_o, ovf_o}, 0);

        // R2 counter enabled but prescaler stopped: no counting
        cnt_run_i = 1'b1;
        repeat (40) @(negedge clk);
        check(count_o == 8'd0, "R2 count with prescaler stopped", count_o, 0);

        // R2 first count 4 cycles after start
        presc_run_i = 1'b1;
        repeat (3) @(negedge clk);
        check(count_o == 8'd0, "R2 no count after 3 cycles", count_o, 0);
        @(negedge clk);
        check(count_o == 8'd1, "R2 first count after 4 cycles", count_o, 1);

        // R2 stop mid-phase, restart: the phase must start over
        repeat (2) @(negedge clk);
        presc_run_i = 1'b0;
        @(negedge clk);
        presc_run_i = 1'b1;
        repeat (3) @(negedge clk);
        check(count_o == 8'd1, "R2 restart holds 3 cycles", count_o, 1);
        @(negedge clk);
        check(count_o == 8'd2, "R2 restart count after 4 cycles", count_o, 2);

        // R3 R4 R5 vector table
        foreach (VECS[i]) begin
            clk_sel_i = VECS[i].rate;
            per_sel_i = VECS[i].per;
            write_cmp(VECS[i].cmp);
            measure(per, hi, olen);
            check(per == VECS[i].exp_period, "R3 R4 PWM period", per, VECS[i].exp_period);
            check(hi == VECS[i].exp_high, "R5 PWM high time", hi, VECS[i].exp_high);
            check(olen == 1, "R9 ovf strobe width", olen, 1);
        end

        // R6 buffered write in PWM mode: current period keeps old compare
        clk_sel_i = 2'd0;
        per_sel_i = 2'd2;
        write_cmp(8'd16);
        measure(per, hi, olen);
        g = 0;
        while (count_o != 8'd8 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        write_cmp(8'd40);
        g = 0;
        while (count_o != 8'd20 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        check(pwm_o == 1'b0, "R6 old compare still in force", pwm_o, 0);
        measure(per, hi, olen);
        check(hi == 160, "R6 new compare from next period", hi, 160);

        // R7 timer mode with direct writes
        cnt_run_i    = 1'b0;
        timer_mode_i = 1'b1;
        @(negedge clk);
        write_cmp(8'd5);
        cnt_run_i = 1'b1;
        wait_match(g);
        check(count_o == 8'd5, "R7 count at match", count_o, 5);
        n = 0;
        maxc = 0;
        ovf_seen = 0;
        bad_strobe = 0;
        do begin
            @(negedge clk);
            n++;
            if (int'(count_o) > maxc) maxc = int'(count_o);
            if (ovf_o) ovf_seen = 1;
            if (n == 1 && match_o) bad_strobe = 1;
        end while (!match_o && n < 20000);
        check(n == 24, "R7 match spacing", n, 24);
        check(maxc == 5, "R7 highest count", maxc, 5);
        check(!ovf_seen, "R7 no ovf in timer mode", ovf_seen, 0);
        check(!bad_strobe, "R9 match strobe width", bad_strobe, 0);

        g = 0;
        while (count_o != 8'd0 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        write_cmp(8'd3);
        wait_match(g);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!match_o && n < 20000);
        check(n == 16, "R7 direct write spacing", n, 16);

        // R8 counter stop clears and holds
        cnt_run_i = 1'b0;
        @(negedge clk);
        check(count_o == 8'd0, "R8 cleared on stop", count_o, 0);
        ovf_seen = 0;
        bad_strobe = 0;
        repeat (60) begin
            @(negedge clk);
            if (count_o != 8'd0) bad_strobe = 1;
            if (match_o || ovf_o) ovf_seen = 1;
        end
        check(!bad_strobe, "R8 count held at zero", bad_strobe, 0);
        check(!ovf_seen, "R8 no strobes while stopped", ovf_seen, 0);

        done = 1;
        report();
        $finish;
    end

endmodule